// File: doc/BRIEF.md
# Serial Control Packet Issuer

This block is the host-side sequencer for the serial control path of a daisy chain of memory devices. A requester gives it a command through a valid/ready handshake. The command holds a 4-bit opcode, a 6-bit target device number and a broadcast flag. For each command the block sends one 16-cycle request packet. The packet goes out MSB first on a serial data pin, and a framing pattern on a separate command pin marks where it starts. The whole block is clocked by the slow serial clock, so one clock is one serial bit time.

The block holds back the requester wherever the devices need quiet time. After a reset-set command it waits before the matching reset-clear can go out. After a reset-clear or a fast-clock-mode command it waits before any further command. Reset-set and reset-clear only go out as a pair, with nothing in between. The block consumes and rejects any request that breaks this rule, and any request with a reserved opcode. It sends no packet for a rejected request and pulses an error flag for one clock.

Top module: `serial_ctl_issuer`

## Requirements
- R1: While reset is held, `reqReady` is 1 and `cmdOut`, `sdoOut` and `errPulse` are 0. Whenever no packet is being sent, `cmdOut` and `sdoOut` are 0.
- R2: A request accepted at a clock edge starts its packet in the next cycle. The packet spans 16 cycles and carries one bit per cycle from the word {5'b00000, dev[5], op[3:0], bcast, dev[4:0]}, bit 15 first. Cycles 0 to 4 of the packet are therefore 0.
- R3: `cmdOut` is 1 in packet cycles 0 to 3 and 0 in packet cycles 4 to 15.
- R4: `reqReady` is 0 during every packet cycle and every enforced idle cycle.
- R5: After a reset-set packet (op 4'b0010), at least 16 idle cycles pass before the next packet starts. When the reset-clear request is already waiting, exactly 16 idle cycles pass.
- R6: After a reset-clear packet (op 4'b1011) or a fast-clock packet (op 4'b0100), at least 4 idle cycles pass before the next packet. When the next request is already waiting, exactly 4 idle cycles pass.
- R7: After a read (4'b0000), write (4'b0001) or no-operation (4'b1111) packet, a request that is already waiting starts its packet after exactly 1 idle cycle.
- R8: A request with any other opcode is accepted through the handshake and sends no packet.
- R9: A reset-clear request is rejected and sends no packet unless a reset-set packet was the last packet sent.
- R10: After a reset-set packet, every request other than reset-clear is rejected and sends no packet. The pairing stays pending, and a later reset-clear is accepted.
- R11: `errPulse` is 1 in exactly the cycle after the handshake of a rejected request. An accepted request never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; one bit time per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can take a request this cycle |
| reqOp | input | 4 | Command opcode |
| reqDev | input | 6 | Target device number |
| reqBcast | input | 1 | Broadcast flag: every device responds |
| cmdOut | output | 1 | Packet framing pin |
| sdoOut | output | 1 | Serial request data, MSB first |
| errPulse | output | 1 | One-cycle flag for a rejected request |

## Verification
The rejection path and the pairing path can act in the same cycle. A reset-set packet goes out, and a write request is then queued behind it. Once the gap ends the write is rejected, and the reset-clear request is offered at the very next edge. The error pulse for the write therefore falls in the same cycle as the handshake that accepts the reset-clear. The scoreboard requires both results from that cycle: one error pulse, counted against the expected total, and a correctly laid-out reset-clear packet that is not blocked by the rejection.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int PKT_LEN = 16;
  localparam int DEV_W   = 6;
  localparam int OP_W    = 4;
  localparam int RSV_W   = PKT_LEN - DEV_W - OP_W - 1;

  localparam logic [OP_W-1:0] OP_READ    = 4'b0000;
  localparam logic [OP_W-1:0] OP_WRITE   = 4'b0001;
  localparam logic [OP_W-1:0] OP_RST_SET = 4'b0010;
  localparam logic [OP_W-1:0] OP_FASTCLK = 4'b0100;
  localparam logic [OP_W-1:0] OP_RST_CLR = 4'b1011;
  localparam logic [OP_W-1:0] OP_IDLE    = 4'b1111;

  typedef struct packed {
    logic load;
    logic shift;
    logic drive;
  } dpStrobe_t;

  function automatic logic isLegalOp(input logic [OP_W-1:0] op);
    case (op)
      OP_READ, OP_WRITE, OP_RST_SET, OP_FASTCLK, OP_RST_CLR, OP_IDLE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/scp_datapath.sv
module scp_datapath
  import scp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [OP_W-1:0]  reqOp,
  input  logic [DEV_W-1:0] reqDev,
  input  logic             reqBcast,
  output logic             sdoOut
);
  logic [PKT_LEN-1:0] shiftReg;
  logic [PKT_LEN-1:0] packWord;

  assign packWord = {{RSV_W{1'b0}}, reqDev[DEV_W-1], reqOp, reqBcast, reqDev[DEV_W-2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.load) begin
      shiftReg <= packWord;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[PKT_LEN-2:0], 1'b0};
    end
  end

  assign sdoOut = strobe.drive & shiftReg[PKT_LEN-1];

  // R2: the reserved leading bits of a freshly loaded word are zero
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (shiftReg[PKT_LEN-1 -: RSV_W] == '0));
endmodule

// File: rtl/scp_ctrl.sv
module scp_ctrl
  import scp_pkg::*;
#(
  parameter int SETR_GAP   = 16,
  parameter int SHORT_GAP  = 4,
  parameter int FRAME_HIGH = 4
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [OP_W-1:0] reqOp,
  output logic            reqReady,
  output logic            cmdOut,
  output logic            errPulse,
  output dpStrobe_t       strobe
);
  localparam int CNT_W  = $clog2(PKT_LEN);
  localparam int GAP_W  = $clog2(SETR_GAP + SHORT_GAP + 1);
  localparam int IDLE_W = $clog2(SETR_GAP + 1) + 1;

  typedef enum logic [1:0] {stIdle, stSend, stGap} state_e;

  state_e          state;
  logic [CNT_W-1:0] bitCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [GAP_W-1:0] gapNeed;
  logic [OP_W-1:0]  lastOp;
  logic             pendClr;
  logic             accept, reject, goLoad, lastBit;

  assign reqReady = (state == stIdle);
  assign accept   = reqValid && reqReady;
  assign reject   = !isLegalOp(reqOp)
                  || ((reqOp == OP_RST_CLR) && !pendClr)
                  || (pendClr && (reqOp != OP_RST_CLR));
  assign goLoad   = accept && !reject;
  assign lastBit  = (bitCnt == CNT_W'(PKT_LEN - 1));

  always_comb begin
    case (lastOp)
      OP_RST_SET:             gapNeed = GAP_W'(SETR_GAP - 1);
      OP_RST_CLR, OP_FASTCLK: gapNeed = GAP_W'(SHORT_GAP - 1);
      default:                gapNeed = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= stIdle;
      bitCnt   <= '0;
      gapCnt   <= '0;
      lastOp   <= OP_IDLE;
      pendClr  <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= accept && reject;
      case (state)
        stIdle: begin
          if (goLoad) begin
            state   <= stSend;
            bitCnt  <= '0;
            lastOp  <= reqOp;
            pendClr <= (reqOp == OP_RST_SET);
          end
        end
        stSend: begin
          if (lastBit) begin
            if (gapNeed == '0) begin
              state <= stIdle;
            end else begin
              state  <= stGap;
              gapCnt <= gapNeed;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        stGap: begin
          if (gapCnt == GAP_W'(1)) state <= stIdle;
          gapCnt <= gapCnt - 1'b1;
        end
        default: state <= stIdle;
      endcase
    end
  end

  assign cmdOut       = (state == stSend) && (bitCnt < CNT_W'(FRAME_HIGH));
  assign strobe.load  = goLoad;
  assign strobe.drive = (state == stSend);
  assign strobe.shift = (state == stSend) && !lastBit;

  // Checker state: idle cycles since the end of the last packet (saturating)
  logic [IDLE_W-1:0] idleRun;
  logic              sentOnce;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleRun  <= '0;
      sentOnce <= 1'b0;
    end else if (state == stSend) begin
      idleRun  <= '0;
      sentOnce <= 1'b1;
    end else if (idleRun != IDLE_W'(SETR_GAP)) begin
      idleRun <= idleRun + 1'b1;
    end
  end

  assert_setr_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (goLoad && sentOnce && lastOp == OP_RST_SET) |-> (idleRun >= IDLE_W'(SETR_GAP - 1)));

  assert_short_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (goLoad && sentOnce && (lastOp == OP_RST_CLR || lastOp == OP_FASTCLK))
      |-> (idleRun >= IDLE_W'(SHORT_GAP - 1)));

  assert_pair_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && sentOnce && lastOp == OP_RST_SET) |-> (reqOp == OP_RST_CLR));

  assert_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdOut |-> !reqReady);

  assert_err_after_hs_R11: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(reqValid && reqReady));

  assert_no_reserved_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> isLegalOp(reqOp));
endmodule

// File: rtl/serial_ctl_issuer.sv
module serial_ctl_issuer
  import scp_pkg::*;
#(
  parameter int SETR_GAP   = 16,
  parameter int SHORT_GAP  = 4,
  parameter int FRAME_HIGH = 4
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [OP_W-1:0]  reqOp,
  input  logic [DEV_W-1:0] reqDev,
  input  logic             reqBcast,
  output logic             cmdOut,
  output logic             sdoOut,
  output logic             errPulse
);
  dpStrobe_t strobe;

  scp_ctrl #(
    .SETR_GAP  (SETR_GAP),
    .SHORT_GAP (SHORT_GAP),
    .FRAME_HIGH(FRAME_HIGH)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqOp   (reqOp),
    .reqReady(reqReady),
    .cmdOut  (cmdOut),
    .errPulse(errPulse),
    .strobe  (strobe)
  );

  scp_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqOp   (reqOp),
    .reqDev  (reqDev),
    .reqBcast(reqBcast),
    .sdoOut  (sdoOut)
  );
endmodule

// File: tb/serial_ctl_issuer_bench.sv
module serial_ctl_issuer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [3:0] reqOp = 4'hF;
  logic [5:0] reqDev = '0;
  logic       reqBcast = 1'b0;
  logic       cmdOut, sdoOut, errPulse;

  always #2 clk = ~clk;

  serial_ctl_issuer u_serial_ctl_issuer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqDev(reqDev), .reqBcast(reqBcast),
    .cmdOut(cmdOut), .sdoOut(sdoOut), .errPulse(errPulse)
  );

  typedef struct {
    logic [15:0] word;
    int          idleReq;
    bit          exact;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  int errExp = 0, errSeen = 0, pktExp = 0, pktSeen = 0;
  logic [3:0] prevOp = 4'hF;
  bit havePrev = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] expWord(input logic [3:0] op, input logic [5:0] dev,
                                          input logic bc);
    return {5'b00000, dev[5], op, bc, dev[4:0]};
  endfunction

  function automatic int needIdle(input logic [3:0] op);
    if (op == 4'b0010) return 16;
    if (op == 4'b1011 || op == 4'b0100) return 4;
    return 1;
  endfunction

  // Driver: called at a falling edge; pushes expected packets into the scoreboard
  task automatic issue(input logic [3:0] op, input logic [5:0] dev, input logic bc,
                       input bit accept, input string req);
    bit waited;
    exp_t e;
    reqOp = op; reqDev = dev; reqBcast = bc; reqValid = 1'b1;
    waited = !reqReady;
    while (!reqReady) @(negedge clk);
    if (accept) begin
      e.word    = expWord(op, dev, bc);
      e.idleReq = havePrev ? needIdle(prevOp) : 0;
      e.exact   = waited && havePrev;
      q.push_back(e);
      prevOp   = op;
      havePrev = 1;
      pktExp++;
    end
    @(negedge clk);
    reqValid = 1'b0;
    check(errPulse == !accept, req, "error flag after handshake", errPulse, !accept);
    if (!accept) errExp++;
  endtask

  // Monitor: rebuilds packets from the pins and compares with the scoreboard
  int pktIdx = 0, idleCnt = 0;
  logic [15:0] cap;
  always @(negedge clk) begin
    if (rstN) begin
      if (errPulse) errSeen++;
      if (pktIdx == 0) begin
        if (cmdOut) begin
          cap = '0;
          cap[15] = sdoOut;
          check(!reqReady, "R4", "ready during packet", reqReady, 0);
          if (q.size() == 0) begin
            check(0, "R8", "unexpected packet", 1, 0);
          end else begin
            string tg;
            tg = (q[0].idleReq == 16) ? "R5" : (q[0].idleReq == 4) ? "R6" : "R7";
            if (q[0].exact)
              check(idleCnt == q[0].idleReq, tg, "idle gap", idleCnt, q[0].idleReq);
            else
              check(idleCnt >= q[0].idleReq, tg, "min idle gap", idleCnt, q[0].idleReq);
          end
          pktIdx = 1;
        end else begin
          if (sdoOut) check(0, "R1", "data while idle", 1, 0);
          idleCnt++;
        end
      end else begin
        cap[15-pktIdx] = sdoOut;
        check(cmdOut == (pktIdx < 4), "R3", "frame pin", cmdOut, pktIdx < 4);
        if (reqReady) check(0, "R4", "ready during packet", 1, 0);
        pktIdx++;
        if (pktIdx == 16) begin
          pktSeen++;
          if (q.size() != 0) begin
            check(cap == q[0].word, "R2", "packet word", cap, q[0].word);
            void'(q.pop_front());
          end
          pktIdx = 0;
          idleCnt = 0;
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready in reset", reqReady, 1);
    check(cmdOut == 1'b0, "R1", "cmd in reset", cmdOut, 0);
    check(sdoOut == 1'b0, "R1", "data in reset", sdoOut, 0);
    check(errPulse == 1'b0, "R1", "error in reset", errPulse, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    issue(4'b0001, 6'h2A, 1'b0, 1, "R2");
    issue(4'b0000, 6'h15, 1'b1, 1, "R7");
    issue(4'b1111, 6'h3F, 1'b0, 1, "R7");
    issue(4'b0011, 6'h05, 1'b0, 0, "R8");
    issue(4'b0101, 6'h05, 1'b1, 0, "R8");
    issue(4'b1110, 6'h05, 1'b0, 0, "R8");
    issue(4'b1011, 6'h07, 1'b0, 0, "R9");
    issue(4'b0100, 6'h01, 1'b0, 1, "R6");
    issue(4'b0000, 6'h33, 1'b1, 1, "R6");
    issue(4'b0010, 6'h21, 1'b1, 1, "R5");
    issue(4'b1011, 6'h21, 1'b1, 1, "R5");
    issue(4'b0001, 6'h0C, 1'b0, 1, "R6");
    // R11: rejected write's error pulse shares a cycle with the reset-clear handshake
    issue(4'b0010, 6'h10, 1'b0, 1, "R10");
    issue(4'b0001, 6'h10, 1'b0, 0, "R10");
    issue(4'b1011, 6'h10, 1'b0, 1, "R11");
    issue(4'b0010, 6'h3E, 1'b1, 1, "R10");
    issue(4'b0010, 6'h3E, 1'b1, 0, "R10");
    issue(4'b1111, 6'h3E, 1'b0, 0, "R10");
    issue(4'b1011, 6'h3E, 1'b1, 1, "R10");

    repeat (40) @(negedge clk);
    check(pktSeen == pktExp, "R8", "packet count", pktSeen, pktExp);
    check(q.size() == 0, "R8", "scoreboard drained", q.size(), 0);
    check(errSeen == errExp, "R11", "error pulse count", errSeen, errExp);
    summary();
  end
endmodule